// File: doc/BRIEF.md
# Multislope Conversion Phase Sequencer

This block is the digital timing core of a multislope integrating converter. An 11-bit sequence counter makes one conversion last 2048 clocks. While idle the counter waits at count 0, holding the integrator in zero-integrate and flagging end of conversion. A start request moves the counter on, and the sequencer then walks through a mode-dependent zero-integrate lead-in and a signal-integrate phase whose length matches one mains period. After that come four deintegrate windows. Each window ends in a rest period, and the first three are each followed by a residue times-eight phase. A zero-integrate tail closes the conversion.

The comparator output arrives as a single digital level. The first time it departs from the sign latched for a deintegrate window, that deintegration is stopped one clock after the registered change, and the window is padded with rest until its fixed end. The analog switches are driven by a one-hot control word. A results accumulator follows the reference polarity and per-clock weight outputs, counting by 512, 64, 8 and 1 in the four deintegrations.

Top module: `mslope_seq`

## Requirements
- R1: A conversion is 2048 counts long. `eoc` is 1 exactly when the counter is at 0. With no start pending, the counter stays at 0 and the switch word selects zero-integrate.
- R2: A start pending at count 0 moves the counter to 1 on the next clock. If a start is already pending when a conversion wraps to 0, `eoc` is high for one clock only and the next conversion follows at once.
- R3: A start write latches a pending bit, which is cleared on the clock that leaves count 5. A write made while the counter is at counts 1 to 5 is therefore lost. A write at count 6 or later starts the next conversion when the counter returns to 0.
- R4: With `mode50`=0 (60 Hz), counts 1 to 111 are zero-integrate and counts 112 to 656 (545 clocks) integrate.
- R5: With `mode50`=1 (50 Hz), count 1 is zero-integrate and counts 2 to 656 (655 clocks) integrate. `mode50` and `rd_zero` are captured at conversion start, and later changes have no effect on that conversion.
- R6: When `rd_zero` was 1 at start, the integrate phase selects the input-short control instead of the signal control.
- R7: `sw_o` is always one-hot. Its bits are: bit0 zero-integrate, bit1 signal integrate, bit2 shorted integrate, bit3 deintegrate with polarity 1, bit4 deintegrate with polarity 0, bit5 rest, bit6 times-eight.
- R8: The deintegrate windows last 336 counts each and start at counts 657, 1001, 1345 and 1689. An 8-count times-eight phase follows each of the first three windows. Counts 2025 to 2047 are zero-integrate.
- R9: The polarity of a window is the comparator level seen during the count two before the window starts, that is, the level registered on the clock that closes that count. It is presented on `deint_pol` and holds through the window.
- R10: Suppose the comparator differs from the window polarity during count n. Then count n+1 is the last deintegrate count, and rest runs from n+2 to the end of the window. With no such difference, deintegration fills the whole window.
- R11: `step_wt` is 512, 64, 8 and 1 while deintegrating in windows 1 to 4 respectively, and 0 at all other times.
- R12: `int_flag` is 1 on every count of the integrate phase and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Start command write strobe, one clock |
| mode50 | input | 1 | 1 selects the 50 Hz integrate length, 0 the 60 Hz length |
| rd_zero | input | 1 | 1 shorts the inputs during integration |
| cmp_pos | input | 1 | Comparator: 1 while the integrator output is positive |
| sw_o | output | 7 | One-hot analog switch controls |
| deint_pol | output | 1 | Reference polarity of the current deintegration |
| step_wt | output | 10 | Accumulator weight per deintegrate clock |
| eoc | output | 1 | End of conversion flag |
| int_flag | output | 1 | Integrate phase in progress |

## Verification
The assertions check, on every cycle, that the switch word is one-hot and that idle means zero-integrate. They also check that a weight appears only during deintegration, that the polarity holds for the whole of a deintegration, that the counter advances by one outside count 0, and that the pending start is gone by count 6. Only the bench scenarios can show the absolute phase boundaries for each mode, the read-zero substitution, the exact clock on which a comparator crossing stops a deintegration, a window that runs full because no crossing occurs, and which start writes are lost and which are kept across a wrap.

// File: rtl/mslope_seq.sv
module mslope_seq #(
  parameter int CNT_W    = 11,
  parameter int ZI60     = 111,
  parameter int TI60     = 545,
  parameter int ZI50     = 1,
  parameter int TI50     = 655,
  parameter int DE_WIN   = 336,
  parameter int X8_LEN   = 8,
  parameter int N_DE     = 4,
  parameter int WT_SHIFT = 3,
  parameter int CLR_AT   = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_wr,
  input  logic                                  mode50,
  input  logic                                  rd_zero,
  input  logic                                  cmp_pos,
  output logic [6:0]                            sw_o,
  output logic                                  deint_pol,
  output logic [WT_SHIFT*(N_DE-1):0]            step_wt,
  output logic                                  eoc,
  output logic                                  int_flag
);
  localparam int WT_W     = WT_SHIFT*(N_DE-1) + 1;
  localparam int INT_LAST = (ZI60+TI60 > ZI50+TI50) ? ZI60+TI60 : ZI50+TI50;
  localparam int DE_S0    = INT_LAST + 1;
  localparam int SLOT     = DE_WIN + X8_LEN;

  logic [CNT_W-1:0] cnt;
  logic start_bit, mode_q, rz_q, cmp_q, pol, done;
  int cv, int_s, int_e, win_idx;
  logic [N_DE-1:0] win_hit, x8_hit, ent_hit;
  logic in_int, any_win, any_x8, deint;

  assign cv    = 32'(cnt);
  assign int_s = mode_q ? ZI50 + 1 : ZI60 + 1;
  assign int_e = mode_q ? ZI50 + TI50 : ZI60 + TI60;
  assign in_int = (cv >= int_s) && (cv <= int_e);

  for (genvar k = 0; k < N_DE; k++) begin : g_win
    localparam int S = DE_S0 + k*SLOT;
    assign win_hit[k] = (cv >= S) && (cv <= S + DE_WIN - 1);
    assign ent_hit[k] = (cv == S - 1);
    if (k < N_DE-1) begin : g_x8
      assign x8_hit[k] = (cv >= S + DE_WIN) && (cv <= S + SLOT - 1);
    end else begin : g_nx8
      assign x8_hit[k] = 1'b0;
    end
  end

  always_comb begin
    win_idx = 0;
    for (int k = 0; k < N_DE; k++)
      if (win_hit[k]) win_idx = k;
  end

  assign any_win = |win_hit;
  assign any_x8  = |x8_hit;
  assign deint   = any_win && !done;

  always_comb begin
    sw_o = '0;
    if (in_int)       sw_o[rz_q ? 2 : 1] = 1'b1;
    else if (deint)   sw_o[pol ? 3 : 4]  = 1'b1;
    else if (any_win) sw_o[5] = 1'b1;
    else if (any_x8)  sw_o[6] = 1'b1;
    else              sw_o[0] = 1'b1;
  end

  assign step_wt   = deint ? (WT_W'(1) << (WT_SHIFT*(N_DE-1-win_idx))) : '0;
  assign deint_pol = pol;
  assign eoc       = (cnt == '0);
  assign int_flag  = in_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      start_bit <= 1'b0;
      mode_q    <= 1'b0;
      rz_q      <= 1'b0;
      cmp_q     <= 1'b0;
      pol       <= 1'b0;
      done      <= 1'b0;
    end else begin
      cmp_q <= cmp_pos;
      if (cnt == '0) begin
        if (start_bit) begin
          cnt    <= CNT_W'(1);
          mode_q <= mode50;
          rz_q   <= rd_zero;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cv == CLR_AT)  start_bit <= 1'b0;
      else if (start_wr) start_bit <= 1'b1;
      if (|ent_hit) begin
        pol  <= cmp_q;
        done <= 1'b0;
      end else if (deint && (cmp_q != pol)) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mslope_seq_chk.sv
module mslope_seq_chk #(
  parameter int CNT_W = 11,
  parameter int WT_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             start_bit,
  input logic [6:0]       sw_o,
  input logic             deint_pol,
  input logic [WT_W-1:0]  step_wt,
  input logic             eoc,
  input logic             int_flag
);
  AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_o) == 1); // R7
  AST_IDLE_ZERO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (sw_o[0] && !int_flag)); // R1
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && start_bit) |=> !eoc); // R2
  AST_START_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(6)) |-> !start_bit); // R3
  AST_WT_IN_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wt != '0) |-> (sw_o[3] || sw_o[4])); // R11
  AST_WT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_o[3] || sw_o[4]) |-> ($countones(step_wt) == 1)); // R11
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_o[3] || sw_o[4]) && $past(sw_o[3] || sw_o[4])) |-> $stable(deint_pol)); // R9
  AST_INT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(sw_o[0])); // R12
endmodule

bind mslope_seq mslope_seq_chk #(.CNT_W(CNT_W), .WT_W(WT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .start_bit(start_bit), .sw_o(sw_o),
  .deint_pol(deint_pol), .step_wt(step_wt), .eoc(eoc), .int_flag(int_flag));

// File: tb/test_mslope_seq.sv
module test_mslope_seq;
  localparam int CLK_P = 10;
  localparam logic [6:0] ZI = 7'b0000001, SIG = 7'b0000010, SHT = 7'b0000100,
                         DP = 7'b0001000, DN = 7'b0010000, RST = 7'b0100000,
                         X8 = 7'b1000000;

  logic clk = 1'b0, rst_n = 1'b0, start_wr = 1'b0, mode50 = 1'b0, rd_zero = 1'b0, cmp_pos = 1'b1;
  logic [6:0] sw_o;
  logic deint_pol, eoc, int_flag;
  logic [9:0] step_wt;
  int nchk = 0, nfail = 0, c = 0;

  mslope_seq i_mslope_seq (.clk(clk), .rst_n(rst_n), .start_wr(start_wr), .mode50(mode50),
    .rd_zero(rd_zero), .cmp_pos(cmp_pos), .sw_o(sw_o), .deint_pol(deint_pol),
    .step_wt(step_wt), .eoc(eoc), .int_flag(int_flag));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s at count %0d: actual %0d expected %0d", req, what, c, act, exp);
    end
  endtask

  task automatic chk_st(string req, logic [6:0] sw, int wt, int in_f);
    chk(req, "sw_o", int'(sw_o), int'(sw));
    chk(req, "step_wt", int'(step_wt), wt);
    chk(req, "int_flag", int'(int_flag), in_f);
  endtask

  task automatic step();
    @(negedge clk);
    c = (c == 2047) ? 0 : c + 1;
  endtask

  task automatic goto(int t);
    while (c != t) step();
  endtask

  task automatic kick();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    @(negedge clk);
    c = 1;
  endtask

  task automatic t_reset();
    chk("R1", "eoc after reset", int'(eoc), 1);
    chk_st("R1", ZI, 0, 0);
  endtask

  task automatic t_conv60();
    mode50 = 1'b0; rd_zero = 1'b0; cmp_pos = 1'b1;
    kick();
    chk("R2", "eoc at count 1", int'(eoc), 0);
    chk_st("R4", ZI, 0, 0);
    goto(111); chk_st("R4", ZI, 0, 0);
    goto(112); chk_st("R12", SIG, 0, 1);
    goto(656); chk_st("R4", SIG, 0, 1);
    goto(657); chk_st("R8", DP, 512, 0); chk("R9", "deint_pol", int'(deint_pol), 1);
    goto(667); cmp_pos = 1'b0;
    goto(668); chk_st("R10", DP, 512, 0);
    goto(669); chk_st("R10", RST, 0, 0);
    goto(992); chk_st("R8", RST, 0, 0);
    goto(993); chk_st("R8", X8, 0, 0);
    goto(1000); chk_st("R8", X8, 0, 0);
    goto(1001); chk_st("R11", DN, 64, 0); chk("R9", "deint_pol", int'(deint_pol), 0);
    goto(1005); cmp_pos = 1'b1;
    goto(1006); chk_st("R10", DN, 64, 0);
    goto(1007); chk_st("R10", RST, 0, 0);
    goto(1345); chk_st("R11", DP, 8, 0);
    goto(1680); chk_st("R10", DP, 8, 0);
    goto(1681); chk_st("R8", X8, 0, 0);
    goto(1689); chk_st("R11", DP, 1, 0); cmp_pos = 1'b0;
    goto(1690); chk_st("R10", DP, 1, 0);
    goto(1691); chk_st("R10", RST, 0, 0);
    goto(2024); chk_st("R8", RST, 0, 0);
    goto(2025); chk_st("R8", ZI, 0, 0);
    goto(2047); chk("R1", "eoc at 2047", int'(eoc), 0);
    step(); chk("R1", "eoc at wrap", int'(eoc), 1);
    cmp_pos = 1'b1;
  endtask

  task automatic t_conv50_rz();
    mode50 = 1'b1; rd_zero = 1'b1; cmp_pos = 1'b1;
    kick();
    mode50 = 1'b0; rd_zero = 1'b0;
    chk_st("R5", ZI, 0, 0);
    goto(2); chk_st("R6", SHT, 0, 1);
    goto(112); chk_st("R5", SHT, 0, 1);
    goto(656); chk_st("R5", SHT, 0, 1);
    goto(657); chk_st("R8", DP, 512, 0);
    goto(2047); step();
    chk("R1", "eoc at wrap", int'(eoc), 1);
  endtask

  task automatic t_start_rules();
    mode50 = 1'b0; rd_zero = 1'b0; cmp_pos = 1'b1;
    kick();
    goto(5); start_wr = 1'b1;
    step(); start_wr = 1'b0;
    goto(2047); step();
    chk("R3", "eoc at wrap", int'(eoc), 1);
    repeat (3) @(negedge clk);
    chk("R3", "eoc stays idle after lost write", int'(eoc), 1);
    chk_st("R1", ZI, 0, 0);
    kick();
    goto(6); start_wr = 1'b1;
    step(); start_wr = 1'b0;
    goto(2047); step();
    chk("R2", "eoc at wrap with pending start", int'(eoc), 1);
    step();
    chk("R2", "eoc one clock only", int'(eoc), 0);
    chk_st("R3", ZI, 0, 0);
    goto(112); chk_st("R3", SIG, 0, 1);
    goto(2047); step();
    @(negedge clk);
    chk("R1", "idle holds", int'(eoc), 1);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv60();
    t_conv50_rz();
    t_start_rules();
    report();
    $finish;
  end
endmodule